// File: doc/BRIEF.md
# Five-Port Prioritized Buffer RAM Arbiter

This block shares one 16-bit buffer memory among five requesters: four data ports (host, disk, microprocessor, ECC) and a refresh requester. On every clock edge it looks at the pending requests, picks one by fixed priority, and gives that requester a single memory access. The winning data port's address, write data and write enable are put on the memory bus. A refresh grant moves no data and only returns an acknowledge.

Each stored word carries two extra bits, an even parity bit for each byte lane. The block generates them on writes and checks them on reads. A read returns the memory word to the port that issued it together with a parity error flag for each lane. The memory sits outside the block and is a plain synchronous RAM with one cycle of read latency. The address width is a parameter and reaches the full 4 MB buffer (2M words) at 21 bits.

A requester holds its request line high until it sees its grant, then drops it in that same cycle. If it keeps the line high, it is granted again on the next edge unless a higher-priority request is pending.

Top module: `bufram_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after it is released with no request pending, `gnt_o`, `rvalid_o`, `perr_o` and `mem_en_o` are all zero.
- R2: At most one bit of `gnt_o` is set in any cycle. A request sampled at clock edge k sets its grant bit during the cycle that follows edge k. A grant lasts exactly one cycle per sampled edge.
- R3: Request/grant bit indices are host=0, disk=1, microprocessor=2, ECC=3, refresh=4. Priority from highest to lowest is refresh, disk, host, ECC, microprocessor.
- R4: In the cycle a data port is granted, `mem_en_o` is 1 and `mem_addr_o`/`mem_we_o` carry that port's address and write enable. `mem_wdata_o[15:0]` carries its write data, with bit 16 the even parity of bits 7:0 and bit 17 the even parity of bits 15:8.
- R5: One cycle after a read grant (`mem_we_o`=0) to port p, `rvalid_o` is one-hot at bit p and `rdata_o` equals `mem_rdata_i[15:0]`. After a write grant `rvalid_o` stays zero.
- R6: A refresh grant sets `gnt_o[4]` for one cycle with `mem_en_o` low. It is followed by no read data.
- R7: With `rvalid_o` set, `perr_o[0]` is 1 exactly when the XOR of `mem_rdata_i[7:0]` and bit 16 is 1. `perr_o[1]` is the same for bits 15:8 and bit 17. `perr_o` is zero when `rvalid_o` is zero.
- R8: With no request pending at an edge, the following cycle has no grant and `mem_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Request lines, one per requester |
| addr_i | input | 4*ADDR_W | Word address of each data port, port p at bits p*ADDR_W upward |
| wdata_i | input | 64 | Write data of each data port, port p at bits p*16 upward |
| we_i | input | 4 | Write enable of each data port |
| gnt_o | output | 5 | One-cycle grant, one bit per requester |
| rvalid_o | output | 4 | Read data valid, one bit per data port |
| rdata_o | output | 16 | Read data returned to the port flagged in rvalid_o |
| perr_o | output | 2 | Parity error per byte lane of the returned word |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | 18 | Memory write word: data plus lane parity bits |
| mem_rdata_i | input | 18 | Memory read word, one cycle after the read strobe |

## Verification
A request sampled at one edge shows up in the next cycle as a grant, together with the memory strobe, address, write enable and write word. Read data and parity flags follow one cycle later, in the cycle the memory returns the word. The bench changes inputs on falling edges and samples every result at the falling edge that lies after the edge it is due at: grant and bus values one falling edge after the request is raised, and read results one falling edge after that. Priority is checked by raising several requests at once and removing each winner as it is granted. Each later falling edge must then show the next requester in the ranking.

// File: rtl/bufarb_pkg.sv
package bufarb_pkg;

    localparam int unsigned NUM_DATA_PORTS = 4;
    localparam int unsigned NUM_REQ        = NUM_DATA_PORTS + 1;
    localparam int unsigned REQ_IDW        = $clog2(NUM_REQ);

    typedef enum logic [REQ_IDW-1:0] {
        PORT_HOST = 3'd0,
        PORT_DISK = 3'd1,
        PORT_MPU  = 3'd2,
        PORT_ECC  = 3'd3,
        PORT_RFSH = 3'd4
    } port_id_e;

    // Rank 0 (highest) sits in the least significant field.
    localparam logic [NUM_REQ*REQ_IDW-1:0] RANK_ORDER = {
        PORT_MPU, PORT_ECC, PORT_HOST, PORT_DISK, PORT_RFSH
    };

endpackage

// File: rtl/bufarb_prio.sv
module bufarb_prio #(
    parameter int unsigned NREQ  = 5,
    parameter int unsigned IDW   = 3,
    parameter logic [NREQ*IDW-1:0] ORDER = '0
) (
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] win
);

    logic [NREQ-1:0] pend_by_rank;
    logic [NREQ-1:0] higher_pend;

    for (genvar r = 0; r < NREQ; r++) begin : g_rank
        localparam int unsigned ID = int'(ORDER[r*IDW +: IDW]);
        assign pend_by_rank[r] = req[ID];
        if (r == 0) begin : g_top
            assign higher_pend[r] = 1'b0;
        end else begin : g_rest
            assign higher_pend[r] = higher_pend[r-1] | pend_by_rank[r-1];
        end
        assign win[ID] = pend_by_rank[r] & ~higher_pend[r];
    end

endmodule

// File: rtl/bufarb_lane_par.sv
module bufarb_lane_par #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  par
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign par[l] = ^data[l*8 +: 8];
    end

endmodule

// File: rtl/bufarb_bus_mux.sv
module bufarb_bus_mux #(
    parameter int unsigned NDP    = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic [NDP-1:0]        sel,
    input  logic [NDP*ADDR_W-1:0] addr_in,
    input  logic [NDP*DATA_W-1:0] data_in,
    input  logic [NDP-1:0]        we_in,
    output logic [ADDR_W-1:0]     addr_out,
    output logic [DATA_W-1:0]     data_out,
    output logic                  we_out
);

    always_comb begin
        addr_out = '0;
        data_out = '0;
        we_out   = 1'b0;
        for (int p = 0; p < int'(NDP); p++) begin
            if (sel[p]) begin
                addr_out = addr_out | addr_in[p*ADDR_W +: ADDR_W];
                data_out = data_out | data_in[p*DATA_W +: DATA_W];
                we_out   = we_out | we_in[p];
            end
        end
    end

endmodule

// File: rtl/bufram_arbiter.sv
module bufram_arbiter
    import bufarb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NDP    = NUM_DATA_PORTS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NDP:0]                  req_i,
    input  logic [NDP*ADDR_W-1:0]         addr_i,
    input  logic [NDP*DATA_W-1:0]         wdata_i,
    input  logic [NDP-1:0]                we_i,
    output logic [NDP:0]                  gnt_o,
    output logic [NDP-1:0]                rvalid_o,
    output logic [DATA_W-1:0]             rdata_o,
    output logic [DATA_W/8-1:0]           perr_o,
    output logic                          mem_en_o,
    output logic                          mem_we_o,
    output logic [ADDR_W-1:0]             mem_addr_o,
    output logic [DATA_W+DATA_W/8-1:0]    mem_wdata_o,
    input  logic [DATA_W+DATA_W/8-1:0]    mem_rdata_i
);

    localparam int unsigned NREQ  = NDP + 1;
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned MEM_W = DATA_W + LANES;
    localparam int unsigned IDW   = REQ_IDW;
    localparam int unsigned RFSH  = NDP;

    typedef struct packed {
        logic [NREQ-1:0]   gnt;
        logic [NDP-1:0]    rvalid;
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [MEM_W-1:0]  wword;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NREQ-1:0]   win;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;
    logic              sel_we;
    logic [LANES-1:0]  wr_par;
    logic [LANES-1:0]  rd_par;
    logic [LANES-1:0]  rd_mismatch;

    bufarb_prio #(
        .NREQ  (NREQ),
        .IDW   (IDW),
        .ORDER (RANK_ORDER)
    ) u_prio (
        .req (req_i),
        .win (win)
    );

    bufarb_bus_mux #(
        .NDP    (NDP),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .sel      (win[NDP-1:0]),
        .addr_in  (addr_i),
        .data_in  (wdata_i),
        .we_in    (we_i),
        .addr_out (sel_addr),
        .data_out (sel_data),
        .we_out   (sel_we)
    );

    bufarb_lane_par #(.DATA_W(DATA_W)) u_wr_par (
        .data (sel_data),
        .par  (wr_par)
    );

    bufarb_lane_par #(.DATA_W(DATA_W)) u_rd_par (
        .data (mem_rdata_i[DATA_W-1:0]),
        .par  (rd_par)
    );

    assign rd_mismatch = rd_par ^ mem_rdata_i[MEM_W-1:DATA_W];

    always_comb begin
        st_d        = st_q;
        st_d.gnt    = win;
        st_d.en     = |win[NDP-1:0];
        st_d.we     = sel_we & (|win[NDP-1:0]);
        st_d.addr   = sel_addr;
        st_d.wword  = {wr_par, sel_data};
        st_d.rvalid = (st_q.en && !st_q.we) ? st_q.gnt[NDP-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o       = st_q.gnt;
    assign rvalid_o    = st_q.rvalid;
    assign mem_en_o    = st_q.en;
    assign mem_we_o    = st_q.we;
    assign mem_addr_o  = st_q.addr;
    assign mem_wdata_o = st_q.wword;
    assign rdata_o     = mem_rdata_i[DATA_W-1:0];
    assign perr_o      = rd_mismatch & {LANES{|st_q.rvalid}};

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R2

    for (genvar i = 0; i < int'(NREQ); i++) begin : g_chk_req
        AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[i] |-> $past(req_i[i])); // R2
    end

    for (genvar r = 1; r < int'(NREQ); r++) begin : g_chk_rank
        localparam int unsigned LO = int'(RANK_ORDER[r*IDW +: IDW]);
        localparam int unsigned HI = int'(RANK_ORDER[(r-1)*IDW +: IDW]);
        AST_RANK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[LO] |-> !$past(req_i[HI])); // R3
    end

    AST_RFSH_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_o[RFSH] |-> !mem_en_o); // R6

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|rvalid_o) |-> $past(mem_en_o && !mem_we_o)); // R5

    AST_BUS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> (|gnt_o[NDP-1:0])); // R4

    AST_PERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|rvalid_o) |-> (perr_o == '0)); // R7

endmodule

// File: tb/tb_bufram_arbiter.sv
module tb_bufram_arbiter;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NP = 4;
    localparam int MW = 18;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NP:0]       req;
    logic [NP*AW-1:0]  addr;
    logic [NP*DW-1:0]  wdata;
    logic [NP-1:0]     we;
    logic [NP:0]       gnt;
    logic [NP-1:0]     rvalid;
    logic [DW-1:0]     rdata;
    logic [1:0]        perr;
    logic              mem_en, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [MW-1:0]     mem_wdata, mem_rdata;

    logic [MW-1:0] ram [256];

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bufram_arbiter #(.ADDR_W(AW), .DATA_W(DW), .NDP(NP)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr), .wdata_i(wdata),
        .we_i(we), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata), .perr_o(perr),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] enc(input logic [DW-1:0] d);
        return {^d[15:8], ^d[7:0], d};
    endfunction

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One access by a data port; checks bus and (for reads) returned word.
    task automatic access(input int p, input bit w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [1:0] exp_perr,
                          input logic [DW-1:0] exp_rd);
        @(negedge clk);
        req[p] = 1'b1;
        we[p]  = w;
        addr[p*AW +: AW] = a;
        wdata[p*DW +: DW] = d;
        @(negedge clk);
        chk(gnt == (5'b1 << p), "R2 grant one cycle after request", 32'(gnt), 32'(5'b1 << p));
        chk(mem_en == 1'b1 && mem_we == w, "R4 strobe and write enable", {mem_en, mem_we}, {1'b1, w});
        chk(mem_addr == a, "R4 address routed", 32'(mem_addr), 32'(a));
        if (w) chk(mem_wdata == enc(d), "R4 write word with lane parity", 32'(mem_wdata), 32'(enc(d)));
        req[p] = 1'b0;
        @(negedge clk);
        if (w) begin
            chk(rvalid == '0, "R5 no read valid after write", 32'(rvalid), 0);
        end else begin
            chk(rvalid == (4'b1 << p), "R5 read valid to issuing port", 32'(rvalid), 32'(4'b1 << p));
            chk(rdata == exp_rd, "R5 read data", 32'(rdata), 32'(exp_rd));
            chk(perr == exp_perr, "R7 lane parity flags", 32'(perr), 32'(exp_perr));
        end
        chk(gnt == '0, "R2 grant lasts one cycle", 32'(gnt), 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(gnt == '0 && rvalid == '0 && mem_en == 1'b0 && perr == '0,
            "R1 outputs quiet in reset", {gnt, rvalid, mem_en, perr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gnt == '0 && rvalid == '0 && mem_en == 1'b0, "R1 quiet after release",
            {gnt, rvalid, mem_en}, 0);
    endtask

    task automatic t_write_read;
        access(0, 1'b1, 8'h10, 16'hA5C3, 2'b00, 16'h0);
        access(1, 1'b1, 8'h22, 16'h0100, 2'b00, 16'h0);
        access(2, 1'b1, 8'h33, 16'hFFFF, 2'b00, 16'h0);
        access(3, 1'b1, 8'hFF, 16'h7F01, 2'b00, 16'h0);
        access(3, 1'b0, 8'h10, 16'h0, 2'b00, 16'hA5C3);
        access(2, 1'b0, 8'h22, 16'h0, 2'b00, 16'h0100);
        access(0, 1'b0, 8'h33, 16'h0, 2'b00, 16'hFFFF);
        access(1, 1'b0, 8'hFF, 16'h0, 2'b00, 16'h7F01);
    endtask

    task automatic t_priority;
        int order [5] = '{4, 1, 0, 3, 2};
        @(negedge clk);
        req = 5'b11111;
        we  = '0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(gnt == (5'b1 << order[k]), "R3 priority ranking", 32'(gnt), 32'(5'b1 << order[k]));
            req[order[k]] = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
        chk(gnt == '0, "R3 all requests served", 32'(gnt), 0);
        // Held request: granted on every edge while held.
        req[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(gnt == 5'b00001, "R2 held request granted again", 32'(gnt), 1);
        req[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_refresh;
        @(negedge clk);
        req[4] = 1'b1;
        @(negedge clk);
        chk(gnt == 5'b10000, "R6 refresh acknowledge", 32'(gnt), 32'h10);
        chk(mem_en == 1'b0, "R6 refresh drives no access", 32'(mem_en), 0);
        req[4] = 1'b0;
        @(negedge clk);
        chk(rvalid == '0 && gnt == '0, "R6 no data after refresh", {gnt, rvalid}, 0);
    endtask

    task automatic t_parity;
        access(1, 1'b1, 8'h40, 16'h3C5A, 2'b00, 16'h0);
        @(negedge clk);
        ram[8'h40][16] = ~ram[8'h40][16];
        access(0, 1'b0, 8'h40, 16'h0, 2'b01, 16'h3C5A);
        @(negedge clk);
        ram[8'h40][17] = ~ram[8'h40][17];
        access(2, 1'b0, 8'h40, 16'h0, 2'b11, 16'h3C5A);
        @(negedge clk);
        ram[8'h40] = enc(16'h3C5A) ^ 18'h01000;
        access(3, 1'b0, 8'h40, 16'h0, 2'b10, 16'h2C5A);
    endtask

    task automatic t_idle;
        @(negedge clk);
        req = '0;
        @(negedge clk);
        @(negedge clk);
        chk(gnt == '0 && mem_en == 1'b0, "R8 idle without request", {gnt, mem_en}, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = '0;
        mem_rdata = '0;
        rst_n = 1'b0;
        req   = '0;
        addr  = '0;
        wdata = '0;
        we    = '0;
        repeat (3) @(posedge clk);
        t_reset();
        t_write_read();
        t_priority();
        t_refresh();
        t_parity();
        t_idle();
        report();
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

endmodule